// File: doc/BRIEF.md
# Dual-Source System Timebase with Compare Frames

This block keeps a 64-bit time count for a chip. The count advances on one of two tick enables: a base-rate tick, where each tick adds one, and an alternate-rate tick, where each tick adds a programmable step. Because of the step, the count stays in base-rate units whichever source is driving it. Software chooses the source with two request bits. A status bit acknowledges the choice after a fixed two-cycle synchronisation delay, and the source changes in that same cycle. An optional hardware request input can take over the choice from the software bits. A debug input can freeze the count when halt-on-debug is enabled.

Two independent compare frames each hold a 64-bit threshold, written as two 32-bit halves, together with an enable and an interrupt mask. A frame raises its status bit once the count has reached its threshold. It drives its own interrupt line while its mask is set. Three read-only words report the tick frequency of each mode. Every register is reached through a single-cycle synchronous write port. Read data is a combinational function of the address.

Top module: `systime_counter`

## Requirements
- R1: After reset, the control word (address 0x00) reads 0x100: run bit 0 clear, halt-on-debug bit 1 clear, base request bit 8 set, alternate request bit 9 clear. The status word (0x01), hardware-switch word (0x02), count words (0x10 low, 0x11 high) and both frame control words read 0. The alternate step (0x03) reads 1 and both interrupt lines are low.
- R2: The frequency words at 0x04, 0x05 and 0x06 read the parameters FREQ_MODE0 (default 24000000), FREQ_MODE1 and FREQ_MODE2. Writes to them have no effect.
- R3: With run set and the base source active, each cycle with baseTick high adds 1 to the count. altTick has no effect.
- R4: With run clear, the count does not change whatever the ticks do.
- R5: With the hardware switch off, the alternate source is chosen only when bit 9 is 1 and bit 8 is 0. Every other combination chooses the base source.
- R6: Status bit 0 reads 1 exactly while the alternate source is active. It takes on a new choice two clock edges after the edge that registered it, and the count source changes on that same edge.
- R7: With the alternate source active, each cycle with altTick high adds the 32-bit step (0x03) to the count. baseTick has no effect.
- R8: When bit 0 of 0x02 is set, the input hwAltReq chooses the source (1 means alternate) and the software request bits are ignored.
- R9: When halt-on-debug is set and dbgHalt is high, the count does not advance. With halt-on-debug clear, dbgHalt has no effect.
- R10: Software writes to 0x10 or 0x11 replace that half of the 64-bit count. A write wins over a tick in the same cycle. Carries pass from the low half to the high half.
- R11: Frame k has its threshold low half at 0x08+4k, its high half at 0x09+4k, and its control word at 0x0A+4k. The control word has enable in bit 0, mask in bit 1 and read-only status in bit 2. Status is 1 one cycle after the frame is enabled and count >= threshold. It clears when the frame is disabled or the threshold rises above the count.
- R12: irqOut[k] is high exactly when frame k's status and mask are both 1.
- R13: The two frames are independent: programming one never changes the other's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register word address |
| busWrEn | input | 1 | Write strobe, applied at the clock edge |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr (combinational) |
| baseTick | input | 1 | Base-rate tick enable |
| altTick | input | 1 | Alternate-rate tick enable |
| dbgHalt | input | 1 | Debug halt request |
| hwAltReq | input | 1 | Hardware source request (1 = alternate) |
| irqOut | output | 2 | Per-frame compare interrupts |

## Verification
Register writes and count increments land on the edge where they are presented, so the bench reads them back at the next falling edge. A new source request reaches the status bit two edges after the write edge. The bench therefore samples the status one and two falling edges after the write and expects the old value, then samples at the third and expects the new one. Compare status and interrupts are registered one edge behind the count and the threshold. In the sweep, the count is frozen and the bench waits two edges after the last write before it samples.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 64;
  localparam int NUM_FRAMES = 2;
  localparam int ADDR_W     = 5;

  localparam int A_CTRL    = 'h00;
  localparam int A_STAT    = 'h01;
  localparam int A_HWSW    = 'h02;
  localparam int A_STEP    = 'h03;
  localparam int A_FREQ    = 'h04;
  localparam int NUM_FREQ  = 3;
  localparam int A_CMP     = 'h08;
  localparam int CMP_PITCH = 4;
  localparam int A_CNTLO   = 'h10;
  localparam int A_CNTHI   = 'h11;

  localparam int B_RUN  = 0;
  localparam int B_HALT = 1;
  localparam int B_REQB = 8;
  localparam int B_REQA = 9;

  localparam int B_CEN   = 0;
  localparam int B_CMASK = 1;
  localparam int B_CSTAT = 2;

  typedef struct packed {
    logic                  cntLoWr;
    logic                  cntHiWr;
    logic [NUM_FRAMES-1:0] cmpLoWr;
    logic [NUM_FRAMES-1:0] cmpHiWr;
    logic                  advance;
    logic [WORD_W-1:0]     step;
    logic [WORD_W-1:0]     wdata;
  } dp_strobe_t;
endpackage

// File: rtl/stb_datapath.sv
module stb_datapath
  import stb_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  dp_strobe_t                       strb,
  input  logic [NUM_FRAMES-1:0]            cmpEn,
  output logic [CNT_W-1:0]                 cntValue,
  output logic [NUM_FRAMES-1:0][CNT_W-1:0] cmpValue,
  output logic [NUM_FRAMES-1:0]            cmpHit
);
  localparam int HALF = CNT_W / 2;

  // software write has priority over a tick in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntValue <= '0;
    end else if (strb.cntLoWr) begin
      cntValue[HALF-1:0] <= strb.wdata;
    end else if (strb.cntHiWr) begin
      cntValue[CNT_W-1:HALF] <= strb.wdata;
    end else if (strb.advance) begin
      cntValue <= cntValue + {{(CNT_W-WORD_W){1'b0}}, strb.step};
    end
  end

  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpValue[k] <= '0;
      end else begin
        if (strb.cmpLoWr[k]) cmpValue[k][HALF-1:0]     <= strb.wdata;
        if (strb.cmpHiWr[k]) cmpValue[k][CNT_W-1:HALF] <= strb.wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) cmpHit[k] <= 1'b0;
      else       cmpHit[k] <= cmpEn[k] && (cntValue >= cmpValue[k]);
    end
  end
endmodule

// File: rtl/stb_ctrl.sv
module stb_ctrl
  import stb_pkg::*;
#(
  parameter logic [WORD_W-1:0] FREQ_MODE0 = 32'd24000000,
  parameter logic [WORD_W-1:0] FREQ_MODE1 = 32'd12000000,
  parameter logic [WORD_W-1:0] FREQ_MODE2 = 32'd32768,
  parameter logic [WORD_W-1:0] STEP_RESET = 32'd1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             busWrEn,
  input  logic [WORD_W-1:0]                busWData,
  output logic [WORD_W-1:0]                busRData,
  input  logic                             baseTick,
  input  logic                             altTick,
  input  logic                             dbgHalt,
  input  logic                             hwAltReq,
  input  logic [CNT_W-1:0]                 cntValue,
  input  logic [NUM_FRAMES-1:0][CNT_W-1:0] cmpValue,
  input  logic [NUM_FRAMES-1:0]            cmpHit,
  output dp_strobe_t                       strb,
  output logic [NUM_FRAMES-1:0]            cmpEn,
  output logic [NUM_FRAMES-1:0]            irqOut,
  output logic                             altWant,
  output logic                             onAlt
);
  localparam int HALF = CNT_W / 2;
  localparam logic [NUM_FREQ-1:0][WORD_W-1:0] FREQ_TABLE = {FREQ_MODE2, FREQ_MODE1, FREQ_MODE0};

  logic runEn, haltEn, reqBase, reqAlt, hwSwEn, syncStage;
  logic [WORD_W-1:0] altStep;
  logic [NUM_FRAMES-1:0] cmpMask;
  logic [NUM_FRAMES-1:0] frmLoSel, frmHiSel, frmCtlSel;

  logic ctrlWr, hwswWr, stepWr;
  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(A_CTRL));
  assign hwswWr = busWrEn && (busAddr == ADDR_W'(A_HWSW));
  assign stepWr = busWrEn && (busAddr == ADDR_W'(A_STEP));

  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_dec
    localparam int FB = A_CMP + CMP_PITCH * k;
    assign frmLoSel[k]  = busAddr == ADDR_W'(FB);
    assign frmHiSel[k]  = busAddr == ADDR_W'(FB + 1);
    assign frmCtlSel[k] = busAddr == ADDR_W'(FB + 2);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpEn[k]   <= 1'b0;
        cmpMask[k] <= 1'b0;
      end else if (busWrEn && frmCtlSel[k]) begin
        cmpEn[k]   <= busWData[B_CEN];
        cmpMask[k] <= busWData[B_CMASK];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      haltEn  <= 1'b0;
      reqBase <= 1'b1;
      reqAlt  <= 1'b0;
      hwSwEn  <= 1'b0;
      altStep <= STEP_RESET;
    end else begin
      if (ctrlWr) begin
        runEn   <= busWData[B_RUN];
        haltEn  <= busWData[B_HALT];
        reqBase <= busWData[B_REQB];
        reqAlt  <= busWData[B_REQA];
      end
      if (hwswWr) hwSwEn  <= busWData[0];
      if (stepWr) altStep <= busWData;
    end
  end

  // source choice, then a two-stage synchroniser; the last stage is the live source
  assign altWant = hwSwEn ? hwAltReq : (reqAlt && !reqBase);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncStage <= 1'b0;
      onAlt     <= 1'b0;
    end else begin
      syncStage <= altWant;
      onAlt     <= syncStage;
    end
  end

  always_comb begin
    strb.cntLoWr = busWrEn && (busAddr == ADDR_W'(A_CNTLO));
    strb.cntHiWr = busWrEn && (busAddr == ADDR_W'(A_CNTHI));
    strb.cmpLoWr = frmLoSel & {NUM_FRAMES{busWrEn}};
    strb.cmpHiWr = frmHiSel & {NUM_FRAMES{busWrEn}};
    strb.advance = runEn && !(haltEn && dbgHalt) && (onAlt ? altTick : baseTick);
    strb.step    = onAlt ? altStep : WORD_W'(1);
    strb.wdata   = busWData;
  end

  assign irqOut = cmpHit & cmpMask;

  always_comb begin
    busRData = '0;
    if (busAddr == ADDR_W'(A_CTRL)) begin
      busRData[B_RUN]  = runEn;
      busRData[B_HALT] = haltEn;
      busRData[B_REQB] = reqBase;
      busRData[B_REQA] = reqAlt;
    end
    if (busAddr == ADDR_W'(A_STAT))  busRData[0] = onAlt;
    if (busAddr == ADDR_W'(A_HWSW))  busRData[0] = hwSwEn;
    if (busAddr == ADDR_W'(A_STEP))  busRData = altStep;
    if (busAddr == ADDR_W'(A_CNTLO)) busRData = cntValue[HALF-1:0];
    if (busAddr == ADDR_W'(A_CNTHI)) busRData = cntValue[CNT_W-1:HALF];
    for (int i = 0; i < NUM_FREQ; i++) begin
      if (busAddr == ADDR_W'(A_FREQ + i)) busRData = FREQ_TABLE[i];
    end
    for (int k = 0; k < NUM_FRAMES; k++) begin
      if (frmLoSel[k]) busRData = cmpValue[k][HALF-1:0];
      if (frmHiSel[k]) busRData = cmpValue[k][CNT_W-1:HALF];
      if (frmCtlSel[k]) begin
        busRData[B_CEN]   = cmpEn[k];
        busRData[B_CMASK] = cmpMask[k];
        busRData[B_CSTAT] = cmpHit[k];
      end
    end
  end
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import stb_pkg::*;
#(
  parameter logic [WORD_W-1:0] FREQ_MODE0 = 32'd24000000,
  parameter logic [WORD_W-1:0] FREQ_MODE1 = 32'd12000000,
  parameter logic [WORD_W-1:0] FREQ_MODE2 = 32'd32768,
  parameter logic [WORD_W-1:0] STEP_RESET = 32'd1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [WORD_W-1:0]     busWData,
  output logic [WORD_W-1:0]     busRData,
  input  logic                  baseTick,
  input  logic                  altTick,
  input  logic                  dbgHalt,
  input  logic                  hwAltReq,
  output logic [NUM_FRAMES-1:0] irqOut
);
  dp_strobe_t                       strb;
  logic [CNT_W-1:0]                 cntValue;
  logic [NUM_FRAMES-1:0][CNT_W-1:0] cmpValue;
  logic [NUM_FRAMES-1:0]            cmpHit;
  logic [NUM_FRAMES-1:0]            cmpEn;
  logic                             altWant;
  logic                             onAlt;

  stb_ctrl #(
    .FREQ_MODE0(FREQ_MODE0),
    .FREQ_MODE1(FREQ_MODE1),
    .FREQ_MODE2(FREQ_MODE2),
    .STEP_RESET(STEP_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWData(busWData), .busRData(busRData),
    .baseTick(baseTick), .altTick(altTick), .dbgHalt(dbgHalt), .hwAltReq(hwAltReq),
    .cntValue(cntValue), .cmpValue(cmpValue), .cmpHit(cmpHit),
    .strb(strb), .cmpEn(cmpEn), .irqOut(irqOut), .altWant(altWant), .onAlt(onAlt)
  );

  stb_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpEn(cmpEn),
    .cntValue(cntValue), .cmpValue(cmpValue), .cmpHit(cmpHit)
  );
endmodule

// File: rtl/systime_counter_chk.sv
module systime_counter_chk
  import stb_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input dp_strobe_t                       strb,
  input logic [CNT_W-1:0]                 cntValue,
  input logic [NUM_FRAMES-1:0][CNT_W-1:0] cmpValue,
  input logic [NUM_FRAMES-1:0]            cmpEn,
  input logic [NUM_FRAMES-1:0]            irqOut,
  input logic                             altWant,
  input logic                             onAlt
);
  logic [1:0] sinceRst;
  logic       cntWrite;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign cntWrite = strb.cntLoWr || strb.cntHiWr;

  assert_ack_delay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (onAlt == $past(altWant, 2)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !cntWrite) |=>
      (cntValue == $past(cntValue) + {{(CNT_W-WORD_W){1'b0}}, $past(strb.step)}));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !cntWrite) |=> $stable(cntValue));

  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_irq
    assert_irq_needs_hit_R12: assert property (@(posedge clk) disable iff (!rstN)
      !(cmpEn[k] && (cntValue >= cmpValue[k])) |=> !irqOut[k]);
  end
endmodule

bind systime_counter systime_counter_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cntValue(cntValue), .cmpValue(cmpValue),
  .cmpEn(cmpEn), .irqOut(irqOut), .altWant(altWant), .onAlt(onAlt)
);

// File: tb/systime_counter_tb.sv
module systime_counter_tb;
  localparam logic [4:0] R_CTRL = 5'h00, R_STAT = 5'h01, R_HWSW = 5'h02, R_STEP = 5'h03;
  localparam logic [4:0] R_FREQ0 = 5'h04, R_CNTLO = 5'h10, R_CNTHI = 5'h11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic baseTick = 1'b0, altTick = 1'b0, dbgHalt = 1'b0, hwAltReq = 1'b0;
  logic [1:0] irqOut;

  int nChecks = 0;
  int nFails = 0;
  logic [63:0] expCnt = '0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  systime_counter u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWData(busWData),
    .busRData(busRData), .baseTick(baseTick), .altTick(altTick), .dbgHalt(dbgHalt),
    .hwAltReq(hwAltReq), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRData;
  endtask

  task automatic ticks(input logic b, input logic a, input int n);
    baseTick = b; altTick = a;
    repeat (n) @(negedge clk);
    baseTick = 1'b0; altTick = 1'b0;
  endtask

  task automatic checkCount(input string req);
    logic [31:0] lo, hi;
    rd(R_CNTLO, lo);
    rd(R_CNTHI, hi);
    check(req, {hi, lo}, expCnt);
  endtask

  task automatic setCount(input logic [63:0] v);
    wr(R_CNTLO, v[31:0]);
    wr(R_CNTHI, v[63:32]);
    expCnt = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(R_CTRL, rv);  check("R1 ctrl", rv, 32'h100);
    rd(R_STAT, rv);  check("R1 stat", rv, 0);
    rd(R_HWSW, rv);  check("R1 hwsw", rv, 0);
    rd(R_STEP, rv);  check("R1 step", rv, 1);
    checkCount("R1 count");
    for (int f = 0; f < 2; f++) begin
      rd(5'(8 + 4 * f + 2), rv); check("R1 frame ctl", rv, 0);
    end
    check("R1 irq", irqOut, 0);

    // R2 frequency table, read-only
    rd(R_FREQ0, rv);    check("R2 mode0", rv, 32'd24000000);
    rd(R_FREQ0 + 1, rv); check("R2 mode1", rv, 32'd12000000);
    rd(R_FREQ0 + 2, rv); check("R2 mode2", rv, 32'd32768);
    wr(R_FREQ0, 32'h1234);
    rd(R_FREQ0, rv);    check("R2 write ignored", rv, 32'd24000000);

    // R4 run clear: no counting
    ticks(1, 1, 6);
    checkCount("R4 stopped");

    // R3 base counting sweep
    wr(R_CTRL, 32'h101);
    for (int n = 0; n < 8; n++) begin
      ticks(1, 0, n);
      expCnt += 64'(n);
      checkCount("R3 base ticks");
    end
    ticks(0, 1, 4);
    checkCount("R3 alt ignored on base");

    // R6 acknowledge latency, R5 select to alternate
    wr(R_CTRL, 32'h201);
    rd(R_STAT, rv); check("R6 ack after 1 edge", rv, 0);
    settle(1);
    rd(R_STAT, rv); check("R6 ack after 2 edges", rv, 0);
    settle(1);
    rd(R_STAT, rv); check("R5 R6 ack after 3 edges", rv, 1);

    // R5 both bits set / both clear choose base
    wr(R_CTRL, 32'h301); settle(3);
    rd(R_STAT, rv); check("R5 both set base", rv, 0);
    wr(R_CTRL, 32'h201); settle(3);
    wr(R_CTRL, 32'h001); settle(3);
    rd(R_STAT, rv); check("R5 both clear base", rv, 0);
    wr(R_CTRL, 32'h201); settle(3);
    rd(R_STAT, rv); check("R5 alt again", rv, 1);

    // R7 alternate step sweep
    for (int s = 0; s < 4; s++) begin
      logic [31:0] st;
      st = (s == 0) ? 32'd1 : (s == 1) ? 32'd3 : (s == 2) ? 32'd7 : 32'd1000;
      wr(R_STEP, st);
      for (int m = 1; m < 5; m += 3) begin
        ticks(0, 1, m);
        expCnt += 64'(st) * 64'(m);
        checkCount("R7 alt ticks");
      end
    end
    ticks(1, 0, 3);
    checkCount("R7 base ignored on alt");

    // R9 debug halt (step is 1000)
    wr(R_CTRL, 32'h203);
    dbgHalt = 1'b1;
    ticks(0, 1, 5);
    checkCount("R9 halted");
    dbgHalt = 1'b0;
    ticks(0, 1, 2);
    expCnt += 64'd2000;
    checkCount("R9 resumed");
    wr(R_CTRL, 32'h201);
    dbgHalt = 1'b1;
    ticks(0, 1, 1);
    expCnt += 64'd1000;
    checkCount("R9 halt bit clear");
    dbgHalt = 1'b0;

    // R8 hardware switch
    wr(R_CTRL, 32'h101); settle(3);
    wr(R_HWSW, 32'h1);
    hwAltReq = 1'b1; settle(3);
    rd(R_STAT, rv); check("R8 hw alt", rv, 1);
    ticks(0, 1, 2);
    expCnt += 64'd2000;
    checkCount("R8 hw alt counting");
    hwAltReq = 1'b0;
    wr(R_CTRL, 32'h201); settle(3);
    rd(R_STAT, rv); check("R8 soft request ignored", rv, 0);
    wr(R_HWSW, 32'h0);
    wr(R_CTRL, 32'h101); settle(3);
    rd(R_STAT, rv); check("R8 back to base", rv, 0);

    // R10 count writes, carry, write priority
    setCount(64'h0000_0000_FFFF_FFFF);
    ticks(1, 0, 1);
    expCnt = 64'h0000_0001_0000_0000;
    checkCount("R10 carry");
    baseTick = 1'b1;
    wr(R_CNTLO, 32'd5);
    baseTick = 1'b0;
    expCnt = 64'h0000_0001_0000_0005;
    checkCount("R10 write wins");

    // R11 R12 R13 compare sweep with the count frozen
    wr(R_CTRL, 32'h100);
    for (int f = 0; f < 2; f++) begin
      for (int ci = 0; ci < 5; ci++) begin
        for (int ti = 0; ti < 5; ti++) begin
          for (int mk = 0; mk < 2; mk++) begin
            logic [63:0] cv, tv;
            logic hit;
            cv = (ci == 0) ? 64'd0 : (ci == 1) ? 64'd5 : (ci == 2) ? 64'hFFFF_FFFF :
                 (ci == 3) ? 64'h1_0000_0000 : 64'h1_0000_0005;
            tv = (ti == 0) ? 64'd0 : (ti == 1) ? 64'd5 : (ti == 2) ? 64'hFFFF_FFFF :
                 (ti == 3) ? 64'h1_0000_0000 : 64'h1_0000_0005;
            wr(5'(8 + 4 * (1 - f) + 2), 32'h0);
            wr(5'(8 + 4 * f), tv[31:0]);
            wr(5'(8 + 4 * f + 1), tv[63:32]);
            wr(5'(8 + 4 * f + 2), {30'd0, mk[0], 1'b1});
            setCount(cv);
            settle(2);
            hit = cv >= tv;
            rd(5'(8 + 4 * f + 2), rv);
            check("R11 status", rv, {29'd0, hit, mk[0], 1'b1});
            check("R12 irq", irqOut[f], hit & mk[0]);
            check("R13 other frame quiet", irqOut[1 - f], 0);
          end
        end
      end
    end

    // R11 clears on disable and on raised threshold
    wr(5'h0A, 32'h3);
    wr(5'h08, 32'h0); wr(5'h09, 32'h0);
    settle(2);
    check("R11 hit before clear", irqOut[0], 1);
    wr(5'h0A, 32'h2); settle(2);
    rd(5'h0A, rv); check("R11 cleared by disable", rv, 32'h2);
    check("R12 irq off when disabled", irqOut[0], 0);
    wr(5'h0A, 32'h3); settle(2);
    wr(5'h09, 32'h7); settle(2);
    rd(5'h0A, rv); check("R11 cleared by raise", rv, 32'h3);
    check("R12 irq off after raise", irqOut[0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule